// File: doc/BRIEF.md
# Supply supervisor and watchdog sequencer

This block is the digital timing core of a processor supervisor. It takes an already synchronised comparator flag for the primary supply and another for a second monitored voltage. It also takes a one-cycle pulse from the serial bus front end each time that front end sees a start condition, and a watchdog enable. It drives an active-low system reset and an active-low secondary-fail output. Both outputs are registered.

Reset is held while the primary supply is low. After the supply recovers, reset stays held for a power-on hold-off, and any dip during that wait restarts the hold-off. Once reset is released and the watchdog is enabled, bus start conditions must keep arriving. If they stop, reset is pulsed for a fixed timeout period. While the primary supply is low, the block asks the serial interface to abort its current command. If a nonvolatile store is already running, the abort is withheld and a store-hold flag is raised instead, so that the store can finish.

All periods are counted in ticks. A tick is a parameterised number of system clocks, so a simulation can use short periods, and each period is a parameter given in ticks.

Top module: `sup_supervisor`

## Requirements
- R1: In the cycle after the primary-low flag is sampled high, the reset output is low. It stays low for as long as the flag stays high.
- R2: Reset rises on exactly the (CLKS_PER_TICK*POR_TICKS+1)-th clock edge at which the primary-low flag is sampled low without a break, counting from the first such edge.
- R3: If the primary-low flag is high for even one edge during the hold-off, the hold-off count restarts from zero. This holds up to and including the edge at which the hold-off would have ended.
- R4: While reset is released and the watchdog enable is high, with no start pulse, reset falls on the (CLKS_PER_TICK*WDT_TICKS+1)-th edge after the edge on which reset rose.
- R5: A start pulse sampled at any edge clears the watchdog count. The next expiry then comes CLKS_PER_TICK*WDT_TICKS+1 edges after that pulse. This includes a pulse at the very edge on which the watchdog would otherwise fire: there the pulse wins.
- R6: After a watchdog expiry, reset stays low for CLKS_PER_TICK*RST_TICKS+1 edges and then rises. The watchdog then counts a full period again from zero.
- R7: While the watchdog enable is low, the watchdog never fires and its count is held at zero. When the enable goes high, a full period of CLKS_PER_TICK*WDT_TICKS+1 edges is counted from the first edge at which the enable is sampled high.
- R8: A primary-low flag takes priority over the watchdog, including at its expiry edge and during its reset timeout. When the flag clears, the full power-on hold-off (R2) applies, not the shorter reset timeout.
- R9: The secondary-fail output equals the inverse of the secondary-low flag as sampled at the previous edge, with no hold-off in either direction.
- R10: One cycle after the primary-low flag and the store-busy input are sampled, the outputs are set as follows:
  - the abort request is high exactly when the primary-low flag is high and no store is busy;
  - the store-hold flag is high exactly when the primary-low flag is high and a store is busy;
  - the abort request and the store-hold flag are never high together.
- R11: While the block's reset is applied, the outputs are: reset low, secondary-fail high (inactive), abort request low and store-hold low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| vcc_low_i | input | 1 | Synchronised primary-supply-low flag |
| v2_low_i | input | 1 | Synchronised secondary-monitor-low flag |
| start_det_i | input | 1 | One-cycle pulse per detected bus start condition |
| wdog_en_i | input | 1 | Watchdog enable |
| nv_store_busy_i | input | 1 | A nonvolatile store is running |
| rst_out_n_o | output | 1 | Active-low system reset, registered |
| v2_fail_n_o | output | 1 | Active-low secondary-fail, registered |
| bus_abort_o | output | 1 | Request to abort the current serial command |
| store_hold_o | output | 1 | Supply is low while a store is allowed to finish |

## Verification
The watchdog expiry can land in the same cycle as either of two other events: a start pulse or a primary-supply dip. The bench sweeps the position of a start pulse across every edge of the watchdog period, including the expiry edge itself. It requires that every position rescues the system and that the next expiry comes exactly one full period after the pulse. It also raises the primary-low flag on the expiry edge and during the reset timeout, and requires that the release then comes after the full power-on hold-off rather than after the shorter timeout. The hold-off restart is swept the same way, with a one-cycle dip at every edge up to and including the edge on which release would have occurred.

// File: rtl/sup_pkg.sv
// Shared types for the supply supervisor.
package sup_pkg;
    // Sequencer states: power-on hold-off, normal run, watchdog reset timeout
    typedef enum logic [1:0] {
        SUP_POR_HOLD = 2'd0,
        SUP_RUN      = 2'd1,
        SUP_WDT_HOLD = 2'd2
    } sup_state_e;
endpackage

// File: rtl/sup_prescaler.sv
// Divides the system clock into ticks of CLKS_PER_TICK clocks.
// Assumes: clear_i restarts the phase, so a period starts exactly when its
// clear is released. tick_o is combinational and is meant for the owning counter.
module sup_prescaler #(
    parameter int CLKS_PER_TICK = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int SUB_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_TICK - 1);

    logic [SUB_W-1:0] sub_q;

    assign tick_o = !clear_i && (sub_q == SUB_LAST);

    // Clock-within-tick counter; wraps at the last clock of a tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) sub_q <= '0;
        else if (sub_q == SUB_LAST) sub_q <= '0;
        else sub_q <= sub_q + 1'b1;
    end
endmodule

// File: rtl/sup_period_cnt.sv
// Counts PERIOD_TICKS ticks after clear_i is released and then flags expiry
// until cleared again.
// Assumes: expired_o is high after exactly CLKS_PER_TICK*PERIOD_TICKS
// uncleared edges.
module sup_period_cnt #(
    parameter int CLKS_PER_TICK = 1000,
    parameter int PERIOD_TICKS  = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int TW = $clog2(PERIOD_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(PERIOD_TICKS);

    logic          tick;
    logic [TW-1:0] ticks_q;

    sup_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .tick_o  (tick)
    );

    assign expired_o = (ticks_q == LAST);

    // Tick counter, saturating at the period length
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) ticks_q <= '0;
        else if (tick && !expired_o) ticks_q <= ticks_q + 1'b1;
    end
endmodule

// File: rtl/sup_supervisor.sv
// Supply supervisor and watchdog sequencer (top).
// Sequences system reset from the primary-low flag (hold-off), from bus start
// activity (watchdog) and from watchdog expiry (reset timeout). It passes the
// secondary-low flag straight to a registered fail output and produces the
// bus abort and store-hold requests.
// Assumes: all inputs are already synchronous to clk; start_det_i is one
// cycle wide.
module sup_supervisor
    import sup_pkg::*;
#(
    parameter int CLKS_PER_TICK = 1000,
    parameter int POR_TICKS     = 150,
    parameter int WDT_TICKS     = 150,
    parameter int RST_TICKS     = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low_i,
    input  logic v2_low_i,
    input  logic start_det_i,
    input  logic wdog_en_i,
    input  logic nv_store_busy_i,
    output logic rst_out_n_o,
    output logic v2_fail_n_o,
    output logic bus_abort_o,
    output logic store_hold_o
);
    sup_state_e state_q, state_d;
    logic por_clr, wdt_clr, rto_clr;
    logic por_exp, wdt_exp, rto_exp;

    // Counter clears: each counter runs only in its own state
    always_comb begin
        por_clr = (state_q != SUP_POR_HOLD) || vcc_low_i;
        wdt_clr = (state_q != SUP_RUN) || !wdog_en_i || start_det_i;
        rto_clr = (state_q != SUP_WDT_HOLD);
    end

    sup_period_cnt #(.CLKS_PER_TICK(CLKS_PER_TICK), .PERIOD_TICKS(POR_TICKS)) u_por (
        .clk(clk), .rst_n(rst_n), .clear_i(por_clr), .expired_o(por_exp)
    );
    sup_period_cnt #(.CLKS_PER_TICK(CLKS_PER_TICK), .PERIOD_TICKS(WDT_TICKS)) u_wdt (
        .clk(clk), .rst_n(rst_n), .clear_i(wdt_clr), .expired_o(wdt_exp)
    );
    sup_period_cnt #(.CLKS_PER_TICK(CLKS_PER_TICK), .PERIOD_TICKS(RST_TICKS)) u_rto (
        .clk(clk), .rst_n(rst_n), .clear_i(rto_clr), .expired_o(rto_exp)
    );

    // Next state: supply low overrides everything; a start beats a same-cycle expiry
    always_comb begin
        state_d = state_q;
        if (vcc_low_i) begin
            state_d = SUP_POR_HOLD;
        end else begin
            case (state_q)
                SUP_POR_HOLD: if (por_exp) state_d = SUP_RUN;
                SUP_RUN:      if (wdog_en_i && wdt_exp && !start_det_i) state_d = SUP_WDT_HOLD;
                SUP_WDT_HOLD: if (rto_exp) state_d = SUP_RUN;
                default:      state_d = SUP_POR_HOLD;
            endcase
        end
    end

    // State register, output flops and request flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SUP_POR_HOLD;
            rst_out_n_o  <= 1'b0;
            v2_fail_n_o  <= 1'b1;
            bus_abort_o  <= 1'b0;
            store_hold_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            rst_out_n_o  <= (state_d == SUP_RUN);
            v2_fail_n_o  <= !v2_low_i;
            bus_abort_o  <= vcc_low_i && !nv_store_busy_i;
            store_hold_o <= vcc_low_i && nv_store_busy_i;
        end
    end
endmodule

// File: rtl/sup_supervisor_chk.sv
// Port-level temporal checks for sup_supervisor, bound to every instance.
// Assumes: it sees only the ports of the top module.
module sup_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic vcc_low_i,
    input logic v2_low_i,
    input logic nv_store_busy_i,
    input logic rst_out_n_o,
    input logic v2_fail_n_o,
    input logic bus_abort_o,
    input logic store_hold_o
);
    // R1
    vcc_low_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low_i |=> !rst_out_n_o);
    // R2
    release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n_o) |-> !$past(vcc_low_i));
    // R9
    v2_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v2_low_i |=> !v2_fail_n_o);
    // R9
    v2_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v2_low_i |=> v2_fail_n_o);
    // R10
    abort_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low_i && !nv_store_busy_i) |=> bus_abort_o);
    // R10
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low_i && nv_store_busy_i) |=> (store_hold_o && !bus_abort_o));
    // R10
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_abort_o, store_hold_o}));
endmodule

bind sup_supervisor sup_supervisor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .vcc_low_i       (vcc_low_i),
    .v2_low_i        (v2_low_i),
    .nv_store_busy_i (nv_store_busy_i),
    .rst_out_n_o     (rst_out_n_o),
    .v2_fail_n_o     (v2_fail_n_o),
    .bus_abort_o     (bus_abort_o),
    .store_hold_o    (store_hold_o)
);

// File: tb/sup_supervisor_test.sv
module sup_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPT = 3;
    localparam int PT  = 4;
    localparam int WT  = 5;
    localparam int RT  = 2;
    localparam int POR_E = CPT * PT + 1;
    localparam int WDT_E = CPT * WT + 1;
    localparam int RTO_E = CPT * RT + 1;

    logic clk = 1'b0;
    logic rst_n, vcc_low, v2_low, start_det, wdog_en, busy;
    logic rst_out_n, v2_fail_n, abort_o, hold_o;
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sup_supervisor #(
        .CLKS_PER_TICK(CPT), .POR_TICKS(PT), .WDT_TICKS(WT), .RST_TICKS(RT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .v2_low_i(v2_low),
        .start_det_i(start_det), .wdog_en_i(wdog_en), .nv_store_busy_i(busy),
        .rst_out_n_o(rst_out_n), .v2_fail_n_o(v2_fail_n),
        .bus_abort_o(abort_o), .store_hold_o(hold_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts edges (sampling at the following negedge) until reset reaches lvl
    task automatic wait_rst(input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (rst_out_n !== lvl && n < 200);
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        bit stayed;
        rst_n = 0; vcc_low = 1; v2_low = 0; start_det = 0; wdog_en = 1; busy = 0;
        repeat (3) cycle();
        // R11 reset values
        check(rst_out_n === 1'b0, "R11 rst_out", rst_out_n, 0);
        check(v2_fail_n === 1'b1, "R11 v2_fail", v2_fail_n, 1);
        check(abort_o === 1'b0 && hold_o === 1'b0, "R11 abort/hold", {abort_o, hold_o}, 0);

        // R2 power-on hold-off from reset release
        rst_n = 1; vcc_low = 0;
        wait_rst(1, n);
        check(n == POR_E, "R2 hold-off edges", n, POR_E);
        // R4 watchdog expiry without starts
        wait_rst(0, n);
        check(n == WDT_E, "R4 watchdog edges", n, WDT_E);
        // R6 reset timeout, then full watchdog period again
        wait_rst(1, n);
        check(n == RTO_E, "R6 timeout edges", n, RTO_E);
        wait_rst(0, n);
        check(n == WDT_E, "R6 rearmed watchdog", n, WDT_E);

        // R8 supply low during the reset timeout: full hold-off applies
        vcc_low = 1;
        repeat (3) cycle();
        check(rst_out_n === 1'b0, "R8 low during timeout", rst_out_n, 0);
        vcc_low = 0;
        wait_rst(1, n);
        check(n == POR_E, "R8 hold-off after timeout", n, POR_E);

        // R3 one-cycle dip at every hold-off position restarts the count
        for (int d = 1; d < POR_E + 1; d++) begin
            vcc_low = 1; cycle(); vcc_low = 0;
            stayed = 1;
            for (int k = 0; k < d - 1; k++) begin
                cycle();
                if (rst_out_n !== 1'b0) stayed = 0;
            end
            vcc_low = 1; cycle(); vcc_low = 0;
            check(stayed && rst_out_n === 1'b0, "R3 held through dip", rst_out_n, 0);
            wait_rst(1, n);
            check(n == POR_E, "R3 restarted hold-off", n, POR_E);
        end

        // R5 start pulse at every watchdog position, expiry edge included
        for (int j = 1; j <= WDT_E; j++) begin
            repeat (j - 1) @(negedge clk);
            start_det = 1; @(negedge clk); start_det = 0;
            check(rst_out_n === 1'b1, "R5 rescued by start", rst_out_n, 1);
            wait_rst(0, n);
            check(n == WDT_E, "R5 period after start", n, WDT_E);
            wait_rst(1, n);
            check(n == RTO_E, "R6 timeout after sweep", n, RTO_E);
        end

        // R8 supply low on the exact expiry edge
        repeat (WDT_E - 1) @(negedge clk);
        vcc_low = 1; cycle();
        check(rst_out_n === 1'b0, "R8 low at expiry", rst_out_n, 0);
        vcc_low = 0;
        wait_rst(1, n);
        check(n == POR_E, "R8 hold-off not timeout", n, POR_E);

        // R7 disabled watchdog never fires; enabling counts a full period
        wdog_en = 0;
        stayed = 1;
        for (int k = 0; k < 3 * WDT_E; k++) begin
            cycle();
            if (rst_out_n !== 1'b1) stayed = 0;
        end
        check(stayed, "R7 disabled no reset", stayed, 1);
        wdog_en = 1;
        wait_rst(0, n);
        check(n == WDT_E, "R7 period after enable", n, WDT_E);

        // R9 secondary fail follows its flag with one register delay
        for (int p = 0; p < 8; p++) begin
            v2_low = (p % 3) == 1;
            cycle();
            check(v2_fail_n === !v2_low, "R9 v2 follow", v2_fail_n, !v2_low);
        end
        v2_low = 0;

        // R10 and R1 abort/hold over all supply and store combinations
        for (int c = 0; c < 4; c++) begin
            vcc_low = c[0]; busy = c[1];
            cycle();
            check(abort_o === (c[0] && !c[1]), "R10 abort", abort_o, c[0] && !c[1]);
            check(hold_o === (c[0] && c[1]), "R10 hold", hold_o, c[0] && c[1]);
            if (c[0]) check(rst_out_n === 1'b0, "R1 reset on low", rst_out_n, 0);
        end
        vcc_low = 0; busy = 0;
        wait_rst(1, n);
        check(n == POR_E, "R2 hold-off after low", n, POR_E);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule